// File: doc/BRIEF.md
# Rotating-Replacement Translation Lookaside Buffer

This block translates 32-bit virtual addresses to physical addresses. It has a fully associative set of entries. Each entry holds a virtual page number, a physical frame number, a write-permission flag and a valid flag. The page size is 4 KiB, so bits [31:12] are the page number and bits [11:0] are the offset.

Addresses whose two top bits are both 1 (0xC0000000 and above) are unmapped. They bypass the entries, and their physical address is the virtual address with bits [31:30] forced to zero. Every other address is mapped. A mapped address is compared with all entries in the same cycle, and the block returns either the frame joined to the offset, a miss, or a write-protect indication.

Software refills the buffer in three steps:
- It loads a page staging register.
- It loads a frame/flag staging register.
- It issues a replacement write.

The replacement write stores the staged pair into the slot chosen by a down-counting replacement index. That index steps once for every mapped lookup. It wraps from the lowest replaceable slot to the top slot, so the low, fixed slots are never overwritten by a replacement write.

Top module: `tlb_rot`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `repl_idx` is 31, `res_valid`, `res_miss` and `res_wprot` are 0, and all entries are invalid. A mapped lookup made right after reset therefore misses.
- R2: A lookup of an unmapped address (bits [31:30] = 2'b11) gives, on the next cycle, `res_paddr` equal to the virtual address with bits [31:30] cleared. For that lookup `res_miss` and `res_wprot` are 0, and `repl_idx` keeps its value.
- R3: Each valid lookup of a mapped address, whether it hits or misses, decrements `repl_idx` by one. With no mapped lookup, `repl_idx` holds.
- R4: When `repl_idx` equals 4 (the fixed-entry count), the next mapped lookup loads 31 instead of decrementing, so `repl_idx` never goes below 4.
- R5: Data written with `stage_hi_we` sets the staged page to `stage_wdata[31:12]`. Data written with `stage_lo_we` sets the staged frame to `stage_wdata[31:12]`, the write flag to `stage_wdata[1]` and the valid flag to `stage_wdata[0]`. `repl_we` copies the staged values into the entry at the current `repl_idx`.
- R6: A mapped lookup that matches a valid entry sets `res_paddr` to {frame, vaddr[11:0]} on the next cycle, with `res_miss` at 0. `res_valid` is the lookup strobe delayed by one cycle.
- R7: A mapped lookup that matches no valid entry sets `res_miss` to 1 and `res_paddr` to 0 on the next cycle. In the same cycle it captures the virtual address into `bad_vaddr` and the access type (1 = write) into `bad_write`.
- R8: A write lookup that hits an entry whose write flag is 0 sets `res_wprot` to 1 and still returns the translated address. A read of the same entry, or a write to an entry whose flag is 1, leaves `res_wprot` at 0. `res_miss` and `res_wprot` are never both 1.
- R9: When a mapped lookup and `repl_we` occur in the same cycle, two things hold. The write goes to the index held before that cycle's step. The lookup is resolved against the entry contents from before the write.
- R10: Entries whose valid flag is 0 never match. If several valid entries hold the same page, the one with the lowest index supplies the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_hi_we | input | 1 | Load the page staging register from `stage_wdata` |
| stage_lo_we | input | 1 | Load the frame/flag staging register from `stage_wdata` |
| stage_wdata | input | 32 | Staging write data |
| repl_we | input | 1 | Write the staged entry at the replacement index |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_vaddr | input | 32 | Virtual address to translate |
| lkp_write | input | 1 | Lookup is a write access |
| res_valid | output | 1 | Registered result strobe |
| res_paddr | output | 32 | Registered physical address |
| res_miss | output | 1 | Registered miss indication |
| res_wprot | output | 1 | Registered write-protect indication |
| bad_vaddr | output | 32 | Virtual address of the last miss |
| bad_write | output | 1 | Access type of the last miss |
| repl_idx | output | 5 | Current replacement index |

## Verification
A table of lookups is run against a few planted entries:
- a read and a write to a writable page;
- a read and a write to a read-only page;
- a page whose valid flag is clear;
- unmapped addresses at both ends of the bypass region;
- the highest mapped page.

Together these separate hit, miss, write-protect and bypass, and each one checks whether the index stepped.

Directed sequences cover the remaining cases:
- Mapped lookups are repeated until the index reaches the fixed-entry boundary, which exposes the wrap point.
- A lookup and a replacement write share one cycle, and a plain write follows. A wrong write slot then shows up as a lost entry, and a lookup that saw the new entry shows up as a hit where a miss is expected.
- Two entries with the same page show which slot has priority.

// File: rtl/tlb_rot_pkg.sv
package tlb_rot_pkg;
  localparam int VA_W_DEF    = 32;
  localparam int PAGE_W_DEF  = 12;
  localparam int ENTRIES_DEF = 32;
  localparam int FIXED_DEF   = 4;

  typedef enum logic [1:0] {
    RES_HIT    = 2'd0,
    RES_BYPASS = 2'd1,
    RES_MISS   = 2'd2
  } res_kind_e;
endpackage

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int ENTRIES = 32,
  parameter int FIXED   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP   = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FLOOR = IDX_W'(FIXED);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= TOP;
    end else if (step) begin
      if (idx == FLOOR) idx <= TOP;
      else              idx <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_pfn,
  input  logic             wr_w,
  input  logic             wr_v,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [VPN_W-1:0] hit_pfn,
  output logic             hit_w
);
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] w_q;
  logic [ENTRIES-1:0] v_q;
  logic [ENTRIES-1:0] match;

  // data fields carry no reset; only the valid flags are cleared
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      w_q[wr_idx]   <= wr_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        v_q <= '0;
    else if (wr_en) v_q[wr_idx] <= wr_v;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = v_q[g] && (vpn_q[g] == lk_vpn);
  end

  // lowest matching index wins
  always_comb begin
    hit     = |match;
    hit_pfn = '0;
    hit_w   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_pfn = pfn_q[i];
        hit_w   = w_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_rot.sv
module tlb_rot
  import tlb_rot_pkg::*;
#(
  parameter int VA_W    = VA_W_DEF,
  parameter int PAGE_W  = PAGE_W_DEF,
  parameter int ENTRIES = ENTRIES_DEF,
  parameter int FIXED   = FIXED_DEF,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stage_hi_we,
  input  logic             stage_lo_we,
  input  logic [VA_W-1:0]  stage_wdata,
  input  logic             repl_we,
  input  logic             lkp_valid,
  input  logic [VA_W-1:0]  lkp_vaddr,
  input  logic             lkp_write,
  output logic             res_valid,
  output logic [VA_W-1:0]  res_paddr,
  output logic             res_miss,
  output logic             res_wprot,
  output logic [VA_W-1:0]  bad_vaddr,
  output logic             bad_write,
  output logic [IDX_W-1:0] repl_idx
);
  localparam int VPN_W = VA_W - PAGE_W;

  logic [VPN_W-1:0] stg_vpn, stg_pfn;
  logic             stg_w, stg_v;
  logic             unused_stage_bits;
  logic             is_mapped, cam_hit, cam_w;
  logic [VPN_W-1:0] cam_pfn;
  res_kind_e        kind;

  assign unused_stage_bits = ^stage_wdata[PAGE_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vpn <= '0;
      stg_pfn <= '0;
      stg_w   <= 1'b0;
      stg_v   <= 1'b0;
    end else begin
      if (stage_hi_we) stg_vpn <= stage_wdata[VA_W-1:PAGE_W];
      if (stage_lo_we) begin
        stg_pfn <= stage_wdata[VA_W-1:PAGE_W];
        stg_w   <= stage_wdata[1];
        stg_v   <= stage_wdata[0];
      end
    end
  end

  assign is_mapped = (lkp_vaddr[VA_W-1:VA_W-2] != 2'b11);

  tlb_repl_ctr #(.ENTRIES(ENTRIES), .FIXED(FIXED), .IDX_W(IDX_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .step(lkp_valid && is_mapped),
    .idx (repl_idx)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (repl_we),
    .wr_idx (repl_idx),
    .wr_vpn (stg_vpn),
    .wr_pfn (stg_pfn),
    .wr_w   (stg_w),
    .wr_v   (stg_v),
    .lk_vpn (lkp_vaddr[VA_W-1:PAGE_W]),
    .hit    (cam_hit),
    .hit_pfn(cam_pfn),
    .hit_w  (cam_w)
  );

  always_comb begin
    if (!is_mapped)   kind = RES_BYPASS;
    else if (cam_hit) kind = RES_HIT;
    else              kind = RES_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_paddr <= '0;
      res_miss  <= 1'b0;
      res_wprot <= 1'b0;
      bad_vaddr <= '0;
      bad_write <= 1'b0;
    end else begin
      res_valid <= lkp_valid;
      res_miss  <= 1'b0;
      res_wprot <= 1'b0;
      if (lkp_valid) begin
        unique case (kind)
          RES_BYPASS: res_paddr <= {2'b00, lkp_vaddr[VA_W-3:0]};
          RES_HIT: begin
            res_paddr <= {cam_pfn, lkp_vaddr[PAGE_W-1:0]};
            res_wprot <= lkp_write && !cam_w;
          end
          default: begin
            res_paddr <= '0;
            res_miss  <= 1'b1;
            bad_vaddr <= lkp_vaddr;
            bad_write <= lkp_write;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_rot_chk.sv
module tlb_rot_chk #(
  parameter int VA_W    = 32,
  parameter int ENTRIES = 32,
  parameter int FIXED   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             lkp_valid,
  input logic [VA_W-1:0]  lkp_vaddr,
  input logic             lkp_write,
  input logic             res_valid,
  input logic [VA_W-1:0]  res_paddr,
  input logic             res_miss,
  input logic             res_wprot,
  input logic [VA_W-1:0]  bad_vaddr,
  input logic             bad_write,
  input logic [IDX_W-1:0] repl_idx
);
  localparam logic [IDX_W-1:0] TOP   = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FLOOR = IDX_W'(FIXED);

  logic mapped_lkp;
  assign mapped_lkp = lkp_valid && (lkp_vaddr[VA_W-1:VA_W-2] != 2'b11);

  p_reset_top_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (repl_idx == TOP && !res_valid && !res_miss && !res_wprot));

  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    repl_idx >= FLOOR);

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mapped_lkp) && $past(repl_idx) == FLOOR) |-> repl_idx == TOP);

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mapped_lkp) && $past(repl_idx) != FLOOR)
      |-> repl_idx == $past(repl_idx) - 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mapped_lkp)) |-> $stable(repl_idx));

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lkp_valid && !mapped_lkp))
      |-> (res_paddr == {2'b00, $past(lkp_vaddr[VA_W-3:0])} && !res_miss && !res_wprot));

  p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_valid == $past(lkp_valid));

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (bad_vaddr == $past(lkp_vaddr) && bad_write == $past(lkp_write)));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(res_miss && res_wprot));
endmodule

bind tlb_rot tlb_rot_chk #(
  .VA_W(VA_W), .ENTRIES(ENTRIES), .FIXED(FIXED), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr),
  .lkp_write(lkp_write), .res_valid(res_valid), .res_paddr(res_paddr),
  .res_miss(res_miss), .res_wprot(res_wprot), .bad_vaddr(bad_vaddr),
  .bad_write(bad_write), .repl_idx(repl_idx)
);

// File: tb/tlb_rot_test.sv
`timescale 1ns/1ps
module tlb_rot_test;
  localparam int FIXED = 4;
  localparam int TOP   = 31;

  logic        clk = 1'b0;
  logic        rst;
  logic        stage_hi_we, stage_lo_we, repl_we, lkp_valid, lkp_write;
  logic [31:0] stage_wdata, lkp_vaddr;
  logic        res_valid, res_miss, res_wprot, bad_write;
  logic [31:0] res_paddr, bad_vaddr;
  logic [4:0]  repl_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_idx;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_rot uut (
    .clk(clk), .rst(rst), .stage_hi_we(stage_hi_we), .stage_lo_we(stage_lo_we),
    .stage_wdata(stage_wdata), .repl_we(repl_we), .lkp_valid(lkp_valid),
    .lkp_vaddr(lkp_vaddr), .lkp_write(lkp_write), .res_valid(res_valid),
    .res_paddr(res_paddr), .res_miss(res_miss), .res_wprot(res_wprot),
    .bad_vaddr(bad_vaddr), .bad_write(bad_write), .repl_idx(repl_idx)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [31:0] pa;
    logic        miss;
    logic        wp;
  } vec_t;

  // planted: page 0x00400 -> 0x12345 writable, 0x00401 -> 0x0ABCD read-only,
  // 0x00402 present but invalid
  localparam vec_t VECS [8] = '{
    '{32'h00400ABC, 1'b0, 32'h12345ABC, 1'b0, 1'b0},
    '{32'h00400FFF, 1'b1, 32'h12345FFF, 1'b0, 1'b0},
    '{32'h00401000, 1'b0, 32'h0ABCD000, 1'b0, 1'b0},
    '{32'h00401123, 1'b1, 32'h0ABCD123, 1'b0, 1'b1},
    '{32'h00402010, 1'b0, 32'h00000000, 1'b1, 1'b0},
    '{32'hC0000010, 1'b0, 32'h00000010, 1'b0, 1'b0},
    '{32'hFFFFFFFF, 1'b1, 32'h3FFFFFFF, 1'b0, 1'b0},
    '{32'hBFFFF004, 1'b0, 32'h00000000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [31:0] va);
    if (va[31:30] != 2'b11) exp_idx = (exp_idx == FIXED) ? TOP : exp_idx - 1;
  endtask

  // all tasks start and end just after a falling edge
  task automatic stage(input logic [31:0] hi, input logic [31:0] lo);
    stage_hi_we = 1'b1; stage_wdata = hi;
    @(negedge clk);
    stage_hi_we = 1'b0; stage_lo_we = 1'b1; stage_wdata = lo;
    @(negedge clk);
    stage_lo_we = 1'b0;
  endtask

  task automatic repl_write();
    repl_we = 1'b1;
    @(negedge clk);
    repl_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic with_wr);
    lkp_valid = 1'b1; lkp_vaddr = va; lkp_write = wr; repl_we = with_wr;
    @(negedge clk);
    lkp_valid = 1'b0; lkp_write = 1'b0; repl_we = 1'b0;
    model_step(va);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; stage_hi_we = 0; stage_lo_we = 0; stage_wdata = '0;
    repl_we = 0; lkp_valid = 0; lkp_vaddr = '0; lkp_write = 0;
    repeat (3) @(negedge clk);
    chk("R1 idx", 32'(repl_idx), 32'(TOP));
    chk("R1 valid", 32'(res_valid), 0);
    chk("R1 miss", 32'(res_miss), 0);
    rst = 1'b0;
    exp_idx = TOP;

    // R1 / R7: empty buffer misses; capture
    lookup(32'h00001000, 1'b0, 1'b0);
    chk("R1 empty miss", 32'(res_miss), 1);
    chk("R7 paddr", res_paddr, 0);
    chk("R7 bad_vaddr", bad_vaddr, 32'h00001000);
    chk("R7 bad_write rd", 32'(bad_write), 0);
    chk("R6 res_valid", 32'(res_valid), 1);
    lookup(32'h00002ABC, 1'b1, 1'b0);
    chk("R7 bad_vaddr2", bad_vaddr, 32'h00002ABC);
    chk("R7 bad_write wr", 32'(bad_write), 1);
    chk("R3 idx", 32'(repl_idx), 32'(exp_idx));

    // R5 fill three entries, stepping between them
    stage(32'h00400000, 32'h12345003); repl_write();
    lookup(32'h7FFFF000, 1'b0, 1'b0);
    stage(32'h00401000, 32'h0ABCD001); repl_write();
    lookup(32'h7FFFF000, 1'b0, 1'b0);
    stage(32'h00402000, 32'h77777002); repl_write();
    lookup(32'h7FFFF000, 1'b0, 1'b0);

    // table: R2 R6 R7 R8 R10
    for (int i = 0; i < 8; i++) begin
      lookup(VECS[i].va, VECS[i].wr, 1'b0);
      chk($sformatf("R6/R2 paddr vec%0d", i), res_paddr, VECS[i].pa);
      chk($sformatf("R7/R10 miss vec%0d", i), 32'(res_miss), 32'(VECS[i].miss));
      chk($sformatf("R8 wprot vec%0d", i), 32'(res_wprot), 32'(VECS[i].wp));
      chk($sformatf("R3/R2 idx vec%0d", i), 32'(repl_idx), 32'(exp_idx));
    end

    // R4: walk to the floor, then wrap
    for (int k = 0; k < 40 && exp_idx != FIXED; k++) begin
      lookup(32'h7FFFF000, 1'b0, 1'b0);
      if (repl_idx < FIXED) chk("R4 floor", 32'(repl_idx), 32'(FIXED));
    end
    chk("R4 at floor", 32'(repl_idx), 32'(FIXED));
    lookup(32'h7FFFF000, 1'b0, 1'b0);
    chk("R4 wrap", 32'(repl_idx), 32'(TOP));

    // R9: same-cycle lookup and replacement write
    stage(32'h00700000, 32'h0BEEF003);
    lookup(32'h00700044, 1'b0, 1'b1);
    chk("R9 sees old contents", 32'(res_miss), 1);
    chk("R9 idx", 32'(repl_idx), 32'(TOP - 1));
    stage(32'h00701000, 32'h0CAFE003); repl_write();
    lookup(32'h00700044, 1'b0, 1'b0);
    chk("R9 slot kept", res_paddr, 32'h0BEEF044);
    lookup(32'h00701010, 1'b0, 1'b0);
    chk("R5 plain write", res_paddr, 32'h0CAFE010);

    // R10: duplicate page, lower index wins
    stage(32'h00800000, 32'h01111003); repl_write();
    lookup(32'h7FFFF000, 1'b0, 1'b0);
    stage(32'h00800000, 32'h02222003); repl_write();
    lookup(32'h00800008, 1'b1, 1'b0);
    chk("R10 lowest wins", res_paddr, 32'h02222008);
    chk("R8 writable no wprot", 32'(res_wprot), 0);
    chk("R3 idx end", 32'(repl_idx), 32'(exp_idx));

    finish_run();
  end
endmodule